// File: doc/BRIEF.md
# Fractional-N Pulse-Swallow Divider

This block is the feedback divider of a frequency synthesizer loop. It runs on the fast input clock and emits a one-clock pulse at the end of every division cycle. Each division cycle lasts P·M + A input clocks, plus one more whenever the fractional accumulator carries. P is the prescaler base modulus (32 or 16, picked by a parameter). M is the main count and A is the swallow count. Over 32 division cycles with a fixed fractional numerator F, exactly F extra clocks are added, so the average ratio is P·M + A + F/32.

The division cycle is a chain of M prescaler cycles. The first A of them last P+1 input clocks and the rest last P clocks. A pending carry appends one stretch clock after the last prescaler cycle.

A 5-bit accumulator adds F once per division cycle. The carry sequence therefore repeats with the reduced denominator of F/32: an even F such as 12 repeats every 8 cycles, the same as 3/8.

Settings are taken only at a division boundary. A flag reports settings outside the usable range. For contiguous channels, the integer ratio P·M + A should be at least 1024 when P = 32, or at least 256 when P = 16. This limit is left to the user and is not flagged.

Top module: `fnd_divider`

## Requirements
- R1: While reset is asserted, and until the first division cycle completes, `div_pulse` is 0. `cfg_err` is 0 during reset.
- R2: The clock count between consecutive `div_pulse` pulses is P·M + min(A, M) + c, where c is 1 when the accumulator carried at the boundary that opened that cycle, and 0 otherwise.
- R3: `div_pulse` is high for exactly one input clock. It rises one clock after the last input clock of the division cycle. The first division cycle starts on the first clock after reset is released.
- R4: With F held constant, any 32 consecutive division cycles span exactly 32·(P·M + A) + F input clocks.
- R5: For F = 12, any 8 consecutive division cycles span exactly 8·(P·M + A) + 3 clocks, which is the reduced fraction 3/8.
- R6: With F = 0, every division cycle has the same length, P·M + A.
- R7: M, A and F are sampled only on the last clock of a division cycle. A change part-way through a cycle leaves that cycle's length unchanged and applies to the next cycle.
- R8: `cfg_err` is set to 1 when the sampled A > M or M < 3, and to 0 otherwise. It is updated only at division boundaries and holds its value in between.
- R9: With A = M and a pending carry, the extra clock is still added, giving P·M + M + 1.
- R10: With P = 16, the A input is 4 bits wide and the ratio is 16·M + A + F/32. With P = 32, A is 5 bits wide.
- R11: With A > M, the swallow count saturates at M, so the cycle lasts (P+1)·M + c clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock being divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| m_in | input | M_W (9) | Main count M, sampled at division boundaries |
| a_in | input | log2(P_MOD) | Swallow count A, sampled at division boundaries |
| f_in | input | F_W (5) | Fractional numerator F over 32 |
| div_pulse | output | 1 | One-clock pulse per division cycle |
| cfg_err | output | 1 | Sampled settings out of range (A > M or M < 3) |

## Verification
The embedded assertions check on every cycle that:
- the prescaler count stays within range;
- the main count moves only on a prescaler wrap or a reload;
- a carry is raised only at a boundary;
- a stretch clock is always followed by the end of the cycle;
- the error flag holds its value between boundaries;
- the output pulse is one clock wide.

The bench is needed to show the actual lengths of the division cycles. It compares both prescaler variants clock by clock against a behavioural countdown model. It also measures windows of 8 and 32 cycles, where the fractional carries must add up exactly. It checks mid-cycle setting changes, the case A = M with a carry, and out-of-range settings.

// File: rtl/fnd_pkg.sv
package fnd_pkg;

    // Smallest main count the divider treats as valid
    localparam int unsigned FND_M_MIN = 3;

    // Position of the current input clock within a division cycle
    typedef enum logic [1:0] {
        PH_RUN,     // inside a prescaler chain
        PH_STRETCH, // extra clock owed to an accumulator carry
        PH_END      // final clock of the division cycle
    } fnd_phase_e;

endpackage

// File: rtl/fnd_prescaler.sv
module fnd_prescaler #(
    parameter int P_MOD = 32,
    parameter int PRE_W = $clog2(P_MOD + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,       // stay at zero for a stretch clock
    input  logic wide_next,  // next prescaler cycle divides by P+1
    output logic wrap        // last input clock of a prescaler cycle
);

    localparam logic [PRE_W-1:0] TOP_WIDE   = PRE_W'(P_MOD);
    localparam logic [PRE_W-1:0] TOP_NARROW = PRE_W'(P_MOD - 1);

    typedef struct packed {
        logic [PRE_W-1:0] cnt;
    } pre_state_t;

    pre_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt == '0) begin
            if (!hold) begin
                st_d.cnt = wide_next ? TOP_WIDE : TOP_NARROW;
            end
        end else begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wrap = (st_q.cnt == '0);

    // R2: a prescaler cycle never exceeds P+1 clocks
    assert_pre_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= TOP_WIDE);

endmodule

// File: rtl/fnd_swallow_main.sv
module fnd_swallow_main #(
    parameter int A_W = 5,
    parameter int M_W = 9
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic           tick,
    input  logic [A_W-1:0] a_val,
    input  logic [M_W-1:0] m_val,
    output logic           mcnt_zero,
    output logic           wide_next
);

    typedef struct packed {
        logic [A_W-1:0] swl;   // wide prescaler cycles left, current one included
        logic [M_W-1:0] mcnt;  // prescaler cycles left after the current one
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        wide_next = (st_q.swl > A_W'(1));
        if (load) begin
            st_d.swl  = a_val;
            st_d.mcnt = m_val - 1'b1;
            wide_next = (a_val != '0);
        end else if (tick) begin
            st_d.mcnt = st_q.mcnt - 1'b1;
            if (st_q.swl != '0) begin
                st_d.swl = st_q.swl - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mcnt_zero = (st_q.mcnt == '0);

    // R7: the main count only moves on a prescaler wrap or a boundary reload
    assert_mcnt_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(load || tick) |=> $stable(st_q.mcnt));

endmodule

// File: rtl/fnd_frac_acc.sv
module fnd_frac_acc #(
    parameter int F_W = 5
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic           stretch,
    input  logic [F_W-1:0] f_val,
    output logic           ext_pending
);

    typedef struct packed {
        logic           ext;
        logic [F_W-1:0] acc;
    } acc_state_t;

    acc_state_t st_d, st_q;
    logic [F_W:0] sum;

    always_comb begin
        st_d = st_q;
        sum  = {1'b0, st_q.acc} + {1'b0, f_val};
        if (load) begin
            {st_d.ext, st_d.acc} = sum;
        end else if (stretch) begin
            st_d.ext = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ext_pending = st_q.ext;

    // R4: a carry can only appear at a division boundary
    assert_carry_at_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> !$rose(st_q.ext));

endmodule

// File: rtl/fnd_divider.sv
module fnd_divider
    import fnd_pkg::*;
#(
    parameter int  P_MOD = 32,
    parameter int  M_W   = 9,
    parameter int  F_W   = 5,
    localparam int A_W   = $clog2(P_MOD),
    localparam int PRE_W = $clog2(P_MOD + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [M_W-1:0] m_in,
    input  logic [A_W-1:0] a_in,
    input  logic [F_W-1:0] f_in,
    output logic           div_pulse,
    output logic           cfg_err
);

    localparam logic [M_W-1:0] M_MIN = M_W'(FND_M_MIN);

    typedef struct packed {
        logic primed;  // first boundary after reset has been taken
        logic pulse;
        logic err;
    } top_state_t;

    top_state_t st_d, st_q;
    fnd_phase_e phase;
    logic       wrap, mcnt_zero, wide_next, ext_pending;
    logic       load, stretch, tick;

    fnd_prescaler #(.P_MOD(P_MOD), .PRE_W(PRE_W)) u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold      (stretch),
        .wide_next (wide_next),
        .wrap      (wrap)
    );

    fnd_swallow_main #(.A_W(A_W), .M_W(M_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .tick      (tick),
        .a_val     (a_in),
        .m_val     (m_in),
        .mcnt_zero (mcnt_zero),
        .wide_next (wide_next)
    );

    fnd_frac_acc #(.F_W(F_W)) u_acc (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (load),
        .stretch     (stretch),
        .f_val       (f_in),
        .ext_pending (ext_pending)
    );

    always_comb begin
        phase = PH_RUN;
        if (wrap && mcnt_zero) begin
            phase = ext_pending ? PH_STRETCH : PH_END;
        end
        load    = (phase == PH_END);
        stretch = (phase == PH_STRETCH);
        tick    = wrap && !mcnt_zero;

        st_d       = st_q;
        st_d.pulse = load && st_q.primed;
        if (load) begin
            st_d.primed = 1'b1;
            st_d.err    = (M_W'(a_in) > m_in) || (m_in < M_MIN);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign div_pulse = st_q.pulse;
    assign cfg_err   = st_q.err;

    // R3: the output pulse is a single clock wide
    assert_pulse_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        div_pulse |=> !div_pulse);

    // R8: the range flag holds between boundaries
    assert_err_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(st_q.err));

    // R2: a stretch clock is always the next-to-last clock of its cycle
    assert_stretch_then_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
        stretch |=> load);

endmodule

// File: tb/tb_fnd_divider.sv
module tb_fnd_divider;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [8:0] m_in = 9'd5;
    logic [4:0] a_in = 5'd3;
    logic [4:0] f_in = 5'd0;
    logic       p32, e32, p16, e16;

    int total = 0;
    int bad   = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    fnd_divider #(.P_MOD(32)) dut (
        .clk(clk), .rst_n(rst_n), .m_in(m_in), .a_in(a_in), .f_in(f_in),
        .div_pulse(p32), .cfg_err(e32)
    );

    fnd_divider #(.P_MOD(16)) dut16 (
        .clk(clk), .rst_n(rst_n), .m_in(m_in), .a_in(a_in[3:0]), .f_in(f_in),
        .div_pulse(p16), .cfg_err(e16)
    );

    // Behavioural model: a countdown per variant, reloaded at each boundary
    int rem [2];
    int acc [2];
    bit prim[2];
    bit xp  [2];
    bit xe  [2];

    function automatic void model_step(int k);
        int pp = (k == 0) ? 32 : 16;
        int mm = int'(m_in);
        int aa = (k == 0) ? int'(a_in) : int'(a_in[3:0]);
        int c;
        bit ld = 1'b0;
        xp[k] = 1'b0;
        if (!prim[k]) begin
            prim[k] = 1'b1;
            ld = 1'b1;
        end else begin
            rem[k]--;
            if (rem[k] == 0) begin
                xp[k] = 1'b1;
                ld = 1'b1;
            end
        end
        if (ld) begin
            acc[k] += int'(f_in);
            c = (acc[k] >= 32) ? 1 : 0;
            acc[k] = acc[k] % 32;
            rem[k] = pp * mm + ((aa < mm) ? aa : mm) + c;
            xe[k]  = (aa > mm) || (mm < 3);
        end
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < 2; k++) begin
                rem[k] = 0; acc[k] = 0; prim[k] = 1'b0; xp[k] = 1'b0; xe[k] = 1'b0;
            end
        end else begin
            for (int k = 0; k < 2; k++) model_step(k);
        end
    end

    task automatic chk(string tag, int act, int exp, string what);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Clock-by-clock comparison against the model (R2, R3, R8, R11)
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R2/R3", int'(p32), int'(xp[0]), "pulse P32");
            chk("R10",   int'(p16), int'(xp[1]), "pulse P16");
            chk("R8",    int'(e32), int'(xe[0]), "cfg_err P32");
            chk("R8",    int'(e16), int'(xe[1]), "cfg_err P16");
        end
    end

    function automatic logic pulse_of(int k);
        return (k == 0) ? p32 : p16;
    endfunction

    // Align to a pulse, then count clocks across n further pulses
    task automatic span(int k, int n, output int clocks);
        int seen = 0;
        clocks = 0;
        do @(negedge clk); while (pulse_of(k) !== 1'b1);
        while (seen < n) begin
            @(negedge clk);
            clocks++;
            if (pulse_of(k) === 1'b1) seen++;
        end
    endtask

    task automatic setv(int m, int a, int f);
        @(negedge clk);
        m_in = 9'(m); a_in = 5'(a); f_in = 5'(f);
    endtask

    initial begin
        repeat (1000000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int t;
        int cnt;
        repeat (4) @(negedge clk);
        // R1: quiet outputs during reset
        chk("R1", int'(p32), 0, "pulse in reset");
        chk("R1", int'(e32), 0, "err in reset");
        chk("R1", int'(p16), 0, "pulse16 in reset");
        rst_n = 1'b1;

        // R6: F = 0, every cycle 32*5+3 = 163 (P32) and 16*5+3 = 83 (P16)
        for (int i = 0; i < 3; i++) begin
            span(0, 1, t); chk("R6", t, 163, "single cycle P32");
        end
        span(1, 1, t); chk("R6", t, 83, "single cycle P16");

        // R7: change settings five clocks into a cycle
        span(0, 1, t);
        cnt = 0;
        repeat (5) begin @(negedge clk); cnt++; end
        m_in = 9'd7; a_in = 5'd2;
        do begin @(negedge clk); cnt++; end while (p32 !== 1'b1);
        chk("R7", cnt, 163, "cycle with mid change");
        cnt = 0;
        do begin @(negedge clk); cnt++; end while (p32 !== 1'b1);
        chk("R7", cnt, 226, "following cycle");

        // R5: F = 12 behaves as 3/8
        setv(5, 3, 12);
        span(0, 8, t); chk("R5", t, 8 * 163 + 3, "8-cycle window P32");
        span(0, 8, t); chk("R5", t, 8 * 163 + 3, "next 8-cycle window P32");
        span(1, 8, t); chk("R5", t, 8 * 83 + 3, "8-cycle window P16");
        // R4: 32-cycle window
        span(0, 32, t); chk("R4", t, 32 * 163 + 12, "32-cycle window F=12");

        // R4 / R10: F = 31, A = 0
        setv(9, 0, 31);
        span(0, 32, t); chk("R4", t, 32 * 288 + 31, "32-cycle window F=31 P32");
        span(1, 32, t); chk("R10", t, 32 * 144 + 31, "32-cycle window F=31 P16");

        // R9: A = M with carries
        setv(6, 6, 1);
        span(0, 32, t); chk("R9", t, 32 * 198 + 1, "A=M window P32");
        span(1, 32, t); chk("R9", t, 32 * 102 + 1, "A=M window P16");

        // R10: P = 16 with the widest A
        setv(15, 15, 0);
        span(1, 1, t); chk("R10", t, 16 * 15 + 15, "A=15 P16");

        // R11 / R8: A > M
        setv(4, 9, 0);
        span(0, 1, t); chk("R11", t, 33 * 4, "A>M cycle P32");
        chk("R8", int'(e32), 1, "A>M flag P32");
        span(1, 1, t); chk("R11", t, 17 * 4, "A>M cycle P16");
        chk("R8", int'(e16), 1, "A>M flag P16");

        // R8: M below minimum
        setv(2, 1, 0);
        span(0, 1, t); chk("R8", int'(e32), 1, "M<3 flag");
        chk("R2", t, 65, "M=2 cycle P32");

        // R8: back in range clears the flag
        setv(3, 2, 0);
        span(0, 1, t); chk("R8", int'(e32), 0, "flag cleared");
        chk("R2", t, 98, "M=3 cycle P32");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule